// File: doc/BRIEF.md
# Main Control Decoder for a Single-Cycle Datapath

This block turns the six-bit opcode field of a fetched instruction into the control strobes of a single-cycle datapath. It drives the branch and jump selects for next-address logic, the destination-register select, the register write enable, the immediate extension mode, the second-operand select, the memory write enable and the write-back source select. It also produces a three-bit ALU operation class that a separate local ALU decoder combines with the function field.

The block is purely combinational. It has two planes. An AND plane matches the opcode against each supported instruction class and produces a one-hot hit vector. An OR plane sums the strobe words of the classes that hit. Because decoding is split in two levels, this block only ever looks at the opcode and never at the function field. Any opcode outside the supported set matches no class, so every strobe falls to zero and nothing is written.

Top module: `mainCtrlDecoder`

## Requirements
- R1: Opcode 000000 (register-register class) drives regDst=1, regWr=1, aluSrc=0, memToReg=0, memWr=0, branch=0, jump=0.
- R2: Opcode 001101 (OR with immediate) drives regDst=0, regWr=1, aluSrc=1, extOp=0 (zero extension), memToReg=0, memWr=0, branch=0, jump=0.
- R3: Opcode 100011 (load word) drives regDst=0, regWr=1, aluSrc=1, extOp=1 (sign extension), memToReg=1, memWr=0, branch=0, jump=0.
- R4: Opcode 101011 (store word) drives memWr=1, regWr=0, aluSrc=1, extOp=1, branch=0, jump=0. regDst and memToReg are not constrained.
- R5: Opcode 000100 (branch on equal) drives branch=1, jump=0, regWr=0, memWr=0, aluSrc=0, extOp=1. regDst and memToReg are not constrained.
- R6: Opcode 000010 (jump) drives jump=1, branch=0, regWr=0, memWr=0.
- R7: regWr is 1 for exactly three opcodes, 000000, 001101 and 100011, and is 0 for the other 61.
- R8: aluOp is 000 (add) for load and store, 001 (subtract) for branch on equal, 010 (or) for OR with immediate, and 100 (take the operation from the function field) for the register-register class.
- R9: Every opcode not named in R1 to R6 drives regWr=0, memWr=0, branch=0 and jump=0.
- R10: No opcode asserts regWr and memWr together, and none asserts branch and jump together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 6 | Instruction bits 31:26 |
| branch | output | 1 | Conditional branch select for next-address logic |
| jump | output | 1 | Absolute jump select for next-address logic |
| regDst | output | 1 | 1 picks the rd field as the write register, 0 picks rt |
| regWr | output | 1 | Register file write enable |
| extOp | output | 1 | 1 sign-extends the 16-bit immediate, 0 zero-extends it |
| aluSrc | output | 1 | 1 feeds the extended immediate to the ALU, 0 feeds the second register |
| memWr | output | 1 | Data memory write enable |
| memToReg | output | 1 | 1 writes memory read data back, 0 writes the ALU result |
| aluOp | output | 3 | Operation class for the local ALU decoder |

## Verification
The assertions treat the opcode as a settled two-state value whenever they sample it. They check the strobes only as a pure function of that value. They assume no X or Z bits on the input and no glitch from a decoder that has not finished evaluating. The stimulus keeps within this. The opcode only ever changes on a rising clock edge, to a defined constant taken from the full 64-code space, and outputs are compared at the following falling edge once the logic has settled. All 64 codes are applied once in ascending order and again in a scattered order, so that every transition between supported and unsupported codes is seen.

// File: rtl/mainCtrl_pkg.sv
package mainCtrl_pkg;

  localparam int OPC_W   = 6;
  localparam int ALUOP_W = 3;
  localparam int NUM_CLS = 6;

  // instruction class indices into the one-hot hit vector
  localparam int CLS_RTYPE = 0;
  localparam int CLS_ORI   = 1;
  localparam int CLS_LW    = 2;
  localparam int CLS_SW    = 3;
  localparam int CLS_BEQ   = 4;
  localparam int CLS_JMP   = 5;

  typedef enum logic [ALUOP_W-1:0] {
    ALU_ADD  = 3'b000,
    ALU_SUB  = 3'b001,
    ALU_OR   = 3'b010,
    ALU_FUNC = 3'b100
  } aluOp_e;

  typedef struct packed {
    logic                branch;
    logic                jump;
    logic                regDst;
    logic                regWr;
    logic                extOp;
    logic                aluSrc;
    logic                memWr;
    logic                memToReg;
    logic [ALUOP_W-1:0]  aluOp;
  } ctrlStrobes_t;

  // opcode minterm of each class
  function automatic logic [OPC_W-1:0] clsOpcode(input int idx);
    case (idx)
      CLS_RTYPE: clsOpcode = 6'b000000;
      CLS_ORI:   clsOpcode = 6'b001101;
      CLS_LW:    clsOpcode = 6'b100011;
      CLS_SW:    clsOpcode = 6'b101011;
      CLS_BEQ:   clsOpcode = 6'b000100;
      CLS_JMP:   clsOpcode = 6'b000010;
      default:   clsOpcode = 6'b111111;
    endcase
  endfunction

  // strobe word contributed by each class; don't-cares resolved to 0
  function automatic ctrlStrobes_t clsStrobes(input int idx);
    ctrlStrobes_t s;
    s = '0;
    case (idx)
      CLS_RTYPE: begin
        s.regDst = 1'b1; s.regWr = 1'b1; s.aluOp = ALU_FUNC;
      end
      CLS_ORI: begin
        s.regWr = 1'b1; s.aluSrc = 1'b1; s.aluOp = ALU_OR;
      end
      CLS_LW: begin
        s.regWr = 1'b1; s.aluSrc = 1'b1; s.extOp = 1'b1;
        s.memToReg = 1'b1; s.aluOp = ALU_ADD;
      end
      CLS_SW: begin
        s.memWr = 1'b1; s.aluSrc = 1'b1; s.extOp = 1'b1; s.aluOp = ALU_ADD;
      end
      CLS_BEQ: begin
        s.branch = 1'b1; s.extOp = 1'b1; s.aluOp = ALU_SUB;
      end
      CLS_JMP: begin
        s.jump = 1'b1;
      end
      default: s = '0;
    endcase
    clsStrobes = s;
  endfunction

endpackage

// File: rtl/opcodeMatch.sv
module opcodeMatch
  import mainCtrl_pkg::*;
(
  input  logic [OPC_W-1:0]   opcode,
  output logic [NUM_CLS-1:0] hit
);
  // AND plane: one full-width minterm per supported class
  for (genvar g = 0; g < NUM_CLS; g++) begin : gMinterm
    localparam logic [OPC_W-1:0] MATCH = clsOpcode(g);
    assign hit[g] = (opcode == MATCH);
  end
endmodule

// File: rtl/ctrlPlane.sv
module ctrlPlane
  import mainCtrl_pkg::*;
(
  input  logic [NUM_CLS-1:0] hit,
  output ctrlStrobes_t       strobes
);
  // OR plane: each strobe is the sum of the minterms that set it
  ctrlStrobes_t terms [NUM_CLS];

  for (genvar g = 0; g < NUM_CLS; g++) begin : gTerm
    localparam ctrlStrobes_t WORD = clsStrobes(g);
    assign terms[g] = hit[g] ? WORD : '0;
  end

  always_comb begin
    strobes = '0;
    for (int i = 0; i < NUM_CLS; i++) begin
      strobes = strobes | terms[i];
    end
  end
endmodule

// File: rtl/mainCtrlDecoder.sv
module mainCtrlDecoder
  import mainCtrl_pkg::*;
(
  input  logic [5:0] opcode,
  output logic       branch,
  output logic       jump,
  output logic       regDst,
  output logic       regWr,
  output logic       extOp,
  output logic       aluSrc,
  output logic       memWr,
  output logic       memToReg,
  output logic [2:0] aluOp
);
  logic [NUM_CLS-1:0] hit;
  ctrlStrobes_t       strobes;

  opcodeMatch u_match (
    .opcode (opcode),
    .hit    (hit)
  );

  ctrlPlane u_plane (
    .hit     (hit),
    .strobes (strobes)
  );

  assign branch   = strobes.branch;
  assign jump     = strobes.jump;
  assign regDst   = strobes.regDst;
  assign regWr    = strobes.regWr;
  assign extOp    = strobes.extOp;
  assign aluSrc   = strobes.aluSrc;
  assign memWr    = strobes.memWr;
  assign memToReg = strobes.memToReg;
  assign aluOp    = strobes.aluOp;
endmodule

// File: rtl/mainCtrlDecoder_chk.sv
module mainCtrlDecoder_chk (
  input logic [5:0] opcode,
  input logic       branch,
  input logic       jump,
  input logic       regDst,
  input logic       regWr,
  input logic       extOp,
  input logic       aluSrc,
  input logic       memWr,
  input logic       memToReg,
  input logic [2:0] aluOp
);
  logic isR, isOri, isLw, isSw, isBeq, isJ, known;
  always_comb begin
    isR   = (opcode == 6'd0);
    isOri = (opcode == 6'd13);
    isLw  = (opcode == 6'd35);
    isSw  = (opcode == 6'd43);
    isBeq = (opcode == 6'd4);
    isJ   = (opcode == 6'd2);
    known = isR | isOri | isLw | isSw | isBeq | isJ;
  end

  always_comb begin
    if (isR) begin
      assert_rtype_dst_R1: assert (regDst && !aluSrc && !memToReg);
    end
    if (isOri) begin
      assert_ori_zext_R2: assert (!extOp && aluSrc && !regDst);
    end
    if (isLw) begin
      assert_load_path_R3: assert (memToReg && aluSrc && extOp && !regDst);
    end
    assert_store_only_R4: assert (memWr == isSw);
    assert_branch_only_R5: assert (branch == isBeq);
    assert_jump_only_R6: assert (jump == isJ);
    assert_regwr_set_R7: assert (regWr == (isR | isOri | isLw));
    if (isR) begin
      assert_func_class_R8: assert (aluOp == 3'b100);
    end
    if (!known) begin
      assert_unknown_safe_R9: assert (!regWr && !memWr && !branch && !jump);
    end
    assert_write_excl_R10: assert (!(regWr && memWr) && !(branch && jump));
  end
endmodule

bind mainCtrlDecoder mainCtrlDecoder_chk u_chk (.*);

// File: tb/mainCtrlDecoder_bench.sv
`timescale 1ns/1ps
module mainCtrlDecoder_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [5:0] opcode = 6'd0;
  logic branch, jump, regDst, regWr, extOp, aluSrc, memWr, memToReg;
  logic [2:0] aluOp;

  mainCtrlDecoder u_mainCtrlDecoder (
    .opcode(opcode), .branch(branch), .jump(jump), .regDst(regDst),
    .regWr(regWr), .extOp(extOp), .aluSrc(aluSrc), .memWr(memWr),
    .memToReg(memToReg), .aluOp(aluOp)
  );

  typedef struct {
    logic [5:0] op;
    logic [7:0] ctlVal;
    logic [7:0] ctlCare;
    logic [2:0] aluVal;
    logic       aluCare;
    string      tag;
  } expItem_t;

  expItem_t sbq[$];
  int checks = 0;
  int fails  = 0;
  int regWrSeen = 0;
  bit done = 1'b0;

  // bit order {branch,jump,regDst,regWr,extOp,aluSrc,memWr,memToReg}
  function automatic expItem_t refModel(input logic [5:0] op);
    expItem_t e;
    e.op = op; e.aluCare = 1'b0; e.aluVal = 3'b000;
    case (op)
      6'b000000: begin e.ctlVal = 8'b0011_0000; e.ctlCare = 8'b1111_0111;
                       e.aluVal = 3'b100; e.aluCare = 1'b1; e.tag = "R1"; end
      6'b001101: begin e.ctlVal = 8'b0001_0100; e.ctlCare = 8'hFF;
                       e.aluVal = 3'b010; e.aluCare = 1'b1; e.tag = "R2"; end
      6'b100011: begin e.ctlVal = 8'b0001_1101; e.ctlCare = 8'hFF;
                       e.aluVal = 3'b000; e.aluCare = 1'b1; e.tag = "R3"; end
      6'b101011: begin e.ctlVal = 8'b0000_1110; e.ctlCare = 8'b1101_1110;
                       e.aluVal = 3'b000; e.aluCare = 1'b1; e.tag = "R4"; end
      6'b000100: begin e.ctlVal = 8'b1000_1000; e.ctlCare = 8'b1101_1110;
                       e.aluVal = 3'b001; e.aluCare = 1'b1; e.tag = "R5"; end
      6'b000010: begin e.ctlVal = 8'b0100_0000; e.ctlCare = 8'b1101_0010;
                       e.tag = "R6"; end
      default:   begin e.ctlVal = 8'b0000_0000; e.ctlCare = 8'b1101_0010;
                       e.tag = "R9"; end
    endcase
    return e;
  endfunction

  task automatic drive(input logic [5:0] op);
    @(posedge clk);
    opcode <= op;
    sbq.push_back(refModel(op));
  endtask

  // monitor: compare at the falling edge after each drive
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && sbq.size() > 0) begin
        expItem_t e;
        logic [7:0] got;
        e = sbq.pop_front();
        got = {branch, jump, regDst, regWr, extOp, aluSrc, memWr, memToReg};
        if (regWr) regWrSeen++;
        checks++;
        if ((got & e.ctlCare) != (e.ctlVal & e.ctlCare)) begin
          fails++;
          $display("FAIL %s op=%b strobes actual=%b expected=%b care=%b",
                   e.tag, e.op, got, e.ctlVal, e.ctlCare);
        end
        if (e.aluCare) begin
          checks++;
          if (aluOp != e.aluVal) begin
            fails++;
            $display("FAIL R8 op=%b aluOp actual=%b expected=%b", e.op, aluOp, e.aluVal);
          end
        end
        // R10: write and redirect exclusivity
        checks++;
        if ((regWr && memWr) || (branch && jump)) begin
          fails++;
          $display("FAIL R10 op=%b actual=%b expected=no overlap", e.op, got);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst <= 1'b0;
    // ascending sweep of all codes
    for (int i = 0; i < 64; i++) drive(6'(i));
    // scattered sweep: stride 37 visits every code once
    for (int i = 0; i < 64; i++) drive(6'((i * 37 + 11) % 64));
    repeat (3) @(posedge clk);
    // R7: exactly three codes per sweep write the register file
    checks++;
    if (regWrSeen != 6) begin
      fails++;
      $display("FAIL R7 regWr count actual=%0d expected=6", regWrSeen);
    end
    checks++;
    if (sbq.size() != 0) begin
      fails++;
      $display("FAIL R7 pending items actual=%0d expected=0", sbq.size());
    end
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d cycles expected=completion", cyc);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule